// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This debug block watches every cycle on the processor bus and raises a break request when a programmed condition is met. It has two comparison channels. Each channel holds a target address, an address-mask mode, an address-space identifier (ASID) and a cycle qualifier. The qualifier restricts matches by access size, by direction and by access kind. The second channel, B, can also compare the bus data under a bit mask.

One control register ties the channels together. In OR mode a match on either channel requests a break. In sequential mode a channel-A match arms the unit, and a later channel-B match fires the break. For instruction fetches, each channel can ask for the break before the instruction executes or after it retires. The control register also keeps a sticky match flag for each channel. Software programs the unit through a simple indexed register port. The block's only other output is a one-cycle break request pulse.

Top module: `bkpt_unit`

## Requirements
- R1: The address-mask code is taken from mask-register bits {3,1,0}. It selects which low address bits the compare ignores: 000 compares all bits, 001 ignores the low 10 bits, 010 ignores the low 12, 100 ignores the low 16, 101 ignores the low 20 and 011 ignores every bit. The two unused codes compare all bits.
- R2: The 8-bit ASID must equal the bus ASID for a match. Setting mask-register bit 2 removes this condition.
- R3: Qualifier bit 6 restricts matches to 64-bit cycles (bus_size 3). With bit 6 clear, qualifier bits [1:0] equal to 1, 2 or 3 restrict matches to byte, 16-bit or 32-bit cycles (bus_size 0, 1 or 2). A value of 0 accepts any size.
- R4: Qualifier bit 2 enables reads and bit 3 enables writes, and both may be set. A channel whose two direction bits are both clear never matches.
- R5: Qualifier bit 4 enables instruction fetches and bit 5 enables data accesses, and both may be set. A channel whose two kind bits are both clear never matches.
- R6: Control bit 7 enables the data compare on channel B. When it is set, a bit whose data-mask bit is 1 is excluded from the compare and every other bit of bus_data must equal the stored data value. When it is clear, bus data has no effect.
- R7: With control bit 3 clear, a match on either channel raises break_req for exactly one cycle, in the cycle after the matching bus cycle. No break_req appears without a cause.
- R8: With control bit 3 set, a channel-A match arms the unit and does not break. A later channel-B match while armed breaks and disarms the unit. A channel-B match while unarmed does nothing. Any write to the control register disarms the unit.
- R9: Control bit 10 (channel A) and bit 6 (channel B) delay a break caused by an instruction-fetch match until insn_retire is seen. The pulse then comes in the cycle after that strobe. Data-access matches are never delayed, and a strobe with nothing pending does nothing.
- R10: Control bit 15 (channel A) and bit 14 (channel B) are match flags. A flag reads 1 from the cycle after its channel matches. It is cleared only by writing 0 to it, and writing 1 leaves it unchanged.
- R11: All registers reset to 0 and read back through reg_rdata in the same cycle, zero-extended. The indices are: 0/4 address of A/B, 1/5 mask (4 bits), 2/6 ASID (8 bits), 3/7 qualifier (7 bits), 8 data of B, 9 data mask of B, and 10 control (writable bits 3, 6, 7 and 10, plus the two flags).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Bus cycle address |
| bus_asid | input | 8 | Address-space identifier of the cycle |
| bus_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_data | input | 32 | Bus cycle data |
| insn_retire | input | 1 | Instruction-retire strobe |
| break_req | output | 1 | One-cycle break request |

## Verification
A break caused by a matching bus cycle must appear one cycle after that cycle. A delayed fetch break must appear one cycle after the retire strobe. Flags become readable one cycle after the match, and register reads are valid in the same cycle the index is presented. The driver records the cycle in which each pulse is due and pushes that cycle number into a queue. A monitor samples on the falling edge, pops the queue whenever break_req is high and compares the cycle numbers. Every bus-cycle task also checks break_req one cycle later, which catches both missing pulses and pulses the requirements forbid.

// File: rtl/bkpt_pkg.sv
// Shared constants for the breakpoint comparator: register indices,
// control/mask/qualifier bit positions and the mask-code decode.
package bkpt_pkg;

    localparam int NCH  = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;

    // Register index map of the software port
    typedef enum logic [3:0] {
        RI_A_ADDR  = 4'd0,
        RI_A_MASK  = 4'd1,
        RI_A_ASID  = 4'd2,
        RI_A_QUAL  = 4'd3,
        RI_B_ADDR  = 4'd4,
        RI_B_MASK  = 4'd5,
        RI_B_ASID  = 4'd6,
        RI_B_QUAL  = 4'd7,
        RI_B_DATA  = 4'd8,
        RI_B_DMASK = 4'd9,
        RI_CTRL    = 4'd10
    } reg_idx_e;

    // Control register bits
    localparam int CB_SEQ   = 3;
    localparam int CB_AFT_B = 6;
    localparam int CB_DEN_B = 7;
    localparam int CB_AFT_A = 10;
    localparam int CB_FLG_B = 14;
    localparam int CB_FLG_A = 15;

    // Mask register bits
    localparam int MASK_W      = 4;
    localparam int MB_ASID_IGN = 2;

    // Qualifier register bits
    localparam int QUAL_W = 7;
    localparam int QB_RD  = 2;
    localparam int QB_WR  = 3;
    localparam int QB_IF  = 4;
    localparam int QB_DA  = 5;
    localparam int QB_DW  = 6;

    // Number of low address bits ignored for a mask code
    function automatic int ignored_low_bits(input logic [MASK_W-1:0] m, input int aw);
        case ({m[3], m[1], m[0]})
            3'b001:  return 10;
            3'b010:  return 12;
            3'b011:  return aw;
            3'b100:  return 16;
            3'b101:  return 20;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/bkpt_chan.sv
// One comparison channel. Purely combinational: raises hit for the
// current bus cycle when address, ASID, size, direction, kind and
// (if enabled) data all qualify. Assumes bus_* are stable during a cycle.
module bkpt_chan
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ASID_W = 8
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic [ASID_W-1:0] cfg_asid,
    input  logic [QUAL_W-1:0] cfg_qual,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [DATA_W-1:0] cfg_dmask,
    input  logic              data_en,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic [1:0]        bus_size,
    input  logic              bus_write,
    input  logic              bus_ifetch,
    input  logic [DATA_W-1:0] bus_data,
    output logic              hit
);

    logic [ADDR_W-1:0] ign;
    logic addr_ok, asid_ok, size_ok, dir_ok, kind_ok, data_ok;

    // Build the ignored-bit vector from the mask code
    always_comb begin
        int n;
        n = ignored_low_bits(cfg_mask, ADDR_W);
        for (int i = 0; i < ADDR_W; i++) ign[i] = (i < n);
    end

    // Per-field qualification
    always_comb begin
        addr_ok = (((bus_addr ^ cfg_addr) & ~ign) == '0);
        asid_ok = cfg_mask[MB_ASID_IGN] || (bus_asid == cfg_asid);
        if (cfg_qual[QB_DW])
            size_ok = (bus_size == 2'd3);
        else if (cfg_qual[1:0] == 2'd0)
            size_ok = 1'b1;
        else
            size_ok = (bus_size == (cfg_qual[1:0] - 2'd1));
        dir_ok  = bus_write ? cfg_qual[QB_WR] : cfg_qual[QB_RD];
        kind_ok = bus_ifetch ? cfg_qual[QB_IF] : cfg_qual[QB_DA];
        data_ok = !data_en || (((bus_data ^ cfg_data) & ~cfg_dmask) == '0);
    end

    // Combine into a channel hit
    assign hit = bus_valid && addr_ok && asid_ok && size_ok && dir_ok && kind_ok && data_ok;

endmodule

// File: rtl/bkpt_regs.sv
// Software-visible register file: per-channel configuration, channel B
// data/mask, control bits and sticky match flags. Writes take effect at
// the clock edge; reads are combinational on reg_addr.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ASID_W = 8,
    parameter int REG_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [3:0]                    reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [NCH-1:0]                hit,
    output logic [NCH-1:0][ADDR_W-1:0]    cfg_addr,
    output logic [NCH-1:0][MASK_W-1:0]    cfg_mask,
    output logic [NCH-1:0][ASID_W-1:0]    cfg_asid,
    output logic [NCH-1:0][QUAL_W-1:0]    cfg_qual,
    output logic [DATA_W-1:0]             cfg_bdata,
    output logic [DATA_W-1:0]             cfg_bdmask,
    output logic                          ctl_seq,
    output logic                          ctl_bdata_en,
    output logic [NCH-1:0]                ctl_after,
    output logic [NCH-1:0]                flags,
    output logic                          ctl_wr
);

    localparam int CH_STRIDE = 4;

    assign ctl_wr = reg_wr && (reg_addr == RI_CTRL);

    // Configuration registers, written by index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr     <= '0;
            cfg_mask     <= '0;
            cfg_asid     <= '0;
            cfg_qual     <= '0;
            cfg_bdata    <= '0;
            cfg_bdmask   <= '0;
            ctl_seq      <= 1'b0;
            ctl_bdata_en <= 1'b0;
            ctl_after    <= '0;
        end else if (reg_wr) begin
            for (int c = 0; c < NCH; c++) begin
                if (reg_addr == 4'(CH_STRIDE*c + 0)) cfg_addr[c] <= reg_wdata[ADDR_W-1:0];
                if (reg_addr == 4'(CH_STRIDE*c + 1)) cfg_mask[c] <= reg_wdata[MASK_W-1:0];
                if (reg_addr == 4'(CH_STRIDE*c + 2)) cfg_asid[c] <= reg_wdata[ASID_W-1:0];
                if (reg_addr == 4'(CH_STRIDE*c + 3)) cfg_qual[c] <= reg_wdata[QUAL_W-1:0];
            end
            if (reg_addr == RI_B_DATA)  cfg_bdata  <= reg_wdata[DATA_W-1:0];
            if (reg_addr == RI_B_DMASK) cfg_bdmask <= reg_wdata[DATA_W-1:0];
            if (reg_addr == RI_CTRL) begin
                ctl_seq         <= reg_wdata[CB_SEQ];
                ctl_bdata_en    <= reg_wdata[CB_DEN_B];
                ctl_after[CH_A] <= reg_wdata[CB_AFT_A];
                ctl_after[CH_B] <= reg_wdata[CB_AFT_B];
            end
        end
    end

    // Sticky flags: set by a hit, cleared only by a written zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags[CH_A] <= hit[CH_A] || (flags[CH_A] && !(ctl_wr && !reg_wdata[CB_FLG_A]));
            flags[CH_B] <= hit[CH_B] || (flags[CH_B] && !(ctl_wr && !reg_wdata[CB_FLG_B]));
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RI_A_ADDR:  reg_rdata = REG_W'(cfg_addr[CH_A]);
            RI_A_MASK:  reg_rdata = REG_W'(cfg_mask[CH_A]);
            RI_A_ASID:  reg_rdata = REG_W'(cfg_asid[CH_A]);
            RI_A_QUAL:  reg_rdata = REG_W'(cfg_qual[CH_A]);
            RI_B_ADDR:  reg_rdata = REG_W'(cfg_addr[CH_B]);
            RI_B_MASK:  reg_rdata = REG_W'(cfg_mask[CH_B]);
            RI_B_ASID:  reg_rdata = REG_W'(cfg_asid[CH_B]);
            RI_B_QUAL:  reg_rdata = REG_W'(cfg_qual[CH_B]);
            RI_B_DATA:  reg_rdata = REG_W'(cfg_bdata);
            RI_B_DMASK: reg_rdata = REG_W'(cfg_bdmask);
            RI_CTRL: begin
                reg_rdata[CB_SEQ]   = ctl_seq;
                reg_rdata[CB_AFT_B] = ctl_after[CH_B];
                reg_rdata[CB_DEN_B] = ctl_bdata_en;
                reg_rdata[CB_AFT_A] = ctl_after[CH_A];
                reg_rdata[CB_FLG_B] = flags[CH_B];
                reg_rdata[CB_FLG_A] = flags[CH_A];
            end
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bkpt_seq.sv
// Break sequencer: combines channel hits per the OR/sequential mode,
// arms on A in sequential mode, holds after-execution breaks until the
// retire strobe, and emits a registered one-cycle break pulse.
module bkpt_seq
    import bkpt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic           bus_ifetch,
    input  logic           seq_mode,
    input  logic [NCH-1:0] after,
    input  logic           ctl_wr,
    input  logic           insn_retire,
    output logic           break_req,
    output logic           armed,
    output logic           pending
);

    logic [NCH-1:0] delayed;
    logic trig, imm, del;

    // Classify the current cycle's break cause
    always_comb begin
        delayed = hit & after & {NCH{bus_ifetch}};
        if (seq_mode) begin
            trig = armed && hit[CH_B];
            imm  = trig && !delayed[CH_B];
            del  = trig && delayed[CH_B];
        end else begin
            trig = |hit;
            imm  = |(hit & ~delayed);
            del  = trig && !imm;
        end
    end

    // Pulse output and after-execution hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            break_req <= 1'b0;
            pending   <= 1'b0;
        end else begin
            break_req <= imm || (pending && insn_retire);
            pending   <= (pending && !insn_retire) || del;
        end
    end

    // Sequential-mode arming
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (ctl_wr || (seq_mode && trig))
            armed <= 1'b0;
        else if (seq_mode && hit[CH_A])
            armed <= 1'b1;
    end

endmodule

// File: rtl/bkpt_unit.sv
// Top of the dual-channel bus breakpoint comparator. Wires the register
// file, two comparison channels and the sequencer. Assumes one bus cycle
// per clock while bus_valid is high.
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ASID_W = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic [1:0]        bus_size,
    input  logic              bus_write,
    input  logic              bus_ifetch,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              insn_retire,
    output logic              break_req
);

    logic [NCH-1:0][ADDR_W-1:0] cfg_addr;
    logic [NCH-1:0][MASK_W-1:0] cfg_mask;
    logic [NCH-1:0][ASID_W-1:0] cfg_asid;
    logic [NCH-1:0][QUAL_W-1:0] cfg_qual;
    logic [DATA_W-1:0]          cfg_bdata, cfg_bdmask;
    logic                       ctl_seq, ctl_bdata_en, ctl_wr;
    logic [NCH-1:0]             ctl_after, flags, hit;
    logic                       armed, pending;

    bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W), .REG_W(REG_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit(hit),
        .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_asid(cfg_asid), .cfg_qual(cfg_qual),
        .cfg_bdata(cfg_bdata), .cfg_bdmask(cfg_bdmask), .ctl_seq(ctl_seq),
        .ctl_bdata_en(ctl_bdata_en), .ctl_after(ctl_after), .flags(flags), .ctl_wr(ctl_wr)
    );

    // One comparator per channel; only channel B gets the data compare
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        bkpt_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W)) chan_i (
            .cfg_addr(cfg_addr[c]), .cfg_mask(cfg_mask[c]), .cfg_asid(cfg_asid[c]),
            .cfg_qual(cfg_qual[c]), .cfg_data(cfg_bdata), .cfg_dmask(cfg_bdmask),
            .data_en((c == CH_B) ? ctl_bdata_en : 1'b0),
            .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid),
            .bus_size(bus_size), .bus_write(bus_write), .bus_ifetch(bus_ifetch),
            .bus_data(bus_data), .hit(hit[c])
        );
    end

    bkpt_seq seq_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .bus_ifetch(bus_ifetch),
        .seq_mode(ctl_seq), .after(ctl_after), .ctl_wr(ctl_wr),
        .insn_retire(insn_retire), .break_req(break_req), .armed(armed), .pending(pending)
    );

endmodule

// File: rtl/bkpt_unit_chk.sv
// Assertion checker for bkpt_unit, attached by bind below.
module bkpt_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hit,
    input logic [1:0] flags,
    input logic       armed,
    input logic       pending,
    input logic       break_req,
    input logic       insn_retire,
    input logic       seq_mode,
    input logic       ctl_wr,
    input logic       bus_ifetch,
    input logic [6:0] qual_a
);

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!break_req && !armed && !pending && flags == 2'b00));

    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> flags[0]);

    p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(hit[1]));

    p_break_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        break_req |-> $past((|hit) || (pending && insn_retire)));

    p_arm_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(seq_mode && hit[0]));

    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !armed);

    p_pending_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(bus_ifetch && (|hit)));

    p_no_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_a[3:2] == 2'b00) |-> !hit[0]);

endmodule

bind bkpt_unit bkpt_unit_chk chk_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .flags(flags), .armed(armed),
    .pending(pending), .break_req(break_req), .insn_retire(insn_retire),
    .seq_mode(ctl_seq), .ctl_wr(ctl_wr), .bus_ifetch(bus_ifetch),
    .qual_a(cfg_qual[0])
);

// File: tb/bkpt_unit_tb_top.sv
// Scoreboard bench: tasks push due cycles of expected breaks, a monitor
// pops them on each observed pulse.
module bkpt_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_asid = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_write = 1'b0;
    logic        bus_ifetch = 1'b0;
    logic [31:0] bus_data = '0;
    logic        insn_retire = 1'b0;
    logic        break_req;

    always #10 clk = ~clk;

    bkpt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_size(bus_size),
        .bus_write(bus_write), .bus_ifetch(bus_ifetch), .bus_data(bus_data),
        .insn_retire(insn_retire), .break_req(break_req)
    );

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    mon_on = 0;
    int    exp_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: every pulse must match the next due cycle
    always @(negedge clk) begin
        int e;
        string t;
        if (mon_on && break_req) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 unexpected break act=cycle %0d exp=none", cyc);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(e == cyc, t, cyc, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic bus(input logic [31:0] a, input logic [7:0] asid, input logic [1:0] sz,
                       input bit w, input bit fe, input logic [31:0] d, input bit exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_asid = asid; bus_size = sz;
        bus_write = w; bus_ifetch = fe; bus_data = d;
        if (exp) begin exp_q.push_back(cyc + 1); tag_q.push_back(req); end
        @(negedge clk);
        bus_valid = 1'b0;
        chk(break_req == exp, req, break_req, exp);
    endtask

    // Shorthand: data read of 32 bits with ASID 5
    task automatic abus(input logic [31:0] a, input bit exp, input string req);
        bus(a, 8'd5, 2'd2, 1'b0, 1'b0, 32'h0, exp, req);
    endtask

    task automatic retire(input bit exp, input string req);
        @(negedge clk);
        insn_retire = 1'b1;
        if (exp) begin exp_q.push_back(cyc + 1); tag_q.push_back(req); end
        @(negedge clk);
        insn_retire = 1'b0;
        chk(break_req == exp, req, break_req, exp);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R7 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    localparam logic [31:0] A_ADR = 32'h8000_1234;
    localparam logic [31:0] B_ADR = 32'h4000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        for (int i = 0; i < 11; i++) rd(4'(i), 32'h0, "R11 reset");
        chk(break_req == 1'b0, "R11 reset break", break_req, 0);
        mon_on = 1;

        // R11 widths and control write-back
        wr(1, 32'hFF);     rd(1, 32'h0F, "R11 mask width");
        wr(3, 32'hFF);     rd(3, 32'h7F, "R11 qual width");
        wr(6, 32'h1A5);    rd(6, 32'hA5, "R11 asid width");
        wr(9, 32'hCAFE_F00D); rd(9, 32'hCAFE_F00D, "R11 dmask");
        wr(10, 32'hFFFF);  rd(10, 32'h04C8, "R11/R10 ctrl readback");
        wr(10, 0); wr(1, 0); wr(3, 0); wr(9, 0);

        // R1 address mask codes on channel A
        wr(0, A_ADR); wr(2, 5); wr(3, 32'h2C);
        abus(A_ADR, 1, "R1 exact match");
        abus(A_ADR + 1, 0, "R1 exact miss");
        wr(1, 1); abus(32'h8000_1000, 1, "R1 low10 hit"); abus(32'h8000_1400, 0, "R1 low10 miss");
        wr(1, 2); abus(32'h8000_1FFF, 1, "R1 low12 hit"); abus(32'h8000_2000, 0, "R1 low12 miss");
        wr(1, 8); abus(32'h8000_FFFF, 1, "R1 low16 hit"); abus(32'h8001_0000, 0, "R1 low16 miss");
        wr(1, 9); abus(32'h800F_FFFF, 1, "R1 low20 hit"); abus(32'h8010_0000, 0, "R1 low20 miss");
        wr(1, 3); abus(32'h0000_0000, 1, "R1 ignore all");
        wr(1, 0);

        // R2 ASID compare and ignore
        bus(A_ADR, 8'd6, 2'd2, 0, 0, 0, 0, "R2 asid miss");
        wr(1, 4);
        bus(A_ADR, 8'd6, 2'd2, 0, 0, 0, 1, "R2 asid ignored");
        wr(1, 0);

        // R3 size qualifier
        wr(3, 32'h2E);
        bus(A_ADR, 5, 2'd1, 0, 0, 0, 1, "R3 16-bit hit");
        bus(A_ADR, 5, 2'd2, 0, 0, 0, 0, "R3 16-bit miss");
        wr(3, 32'h6C);
        bus(A_ADR, 5, 2'd3, 0, 0, 0, 1, "R3 64-bit hit");
        bus(A_ADR, 5, 2'd2, 0, 0, 0, 0, "R3 64-bit miss");
        wr(3, 32'h2C);
        bus(A_ADR, 5, 2'd0, 0, 0, 0, 1, "R3 any size");

        // R4 direction
        wr(3, 32'h24);
        bus(A_ADR, 5, 2'd2, 1, 0, 0, 0, "R4 write on read-only");
        bus(A_ADR, 5, 2'd2, 0, 0, 0, 1, "R4 read on read-only");
        wr(3, 32'h28);
        bus(A_ADR, 5, 2'd2, 1, 0, 0, 1, "R4 write on write-only");
        wr(3, 32'h20);
        bus(A_ADR, 5, 2'd2, 0, 0, 0, 0, "R4 no direction read");
        bus(A_ADR, 5, 2'd2, 1, 0, 0, 0, "R4 no direction write");

        // R5 kind
        wr(3, 32'h1C);
        bus(A_ADR, 5, 2'd2, 0, 0, 0, 0, "R5 data on fetch-only");
        bus(A_ADR, 5, 2'd2, 0, 1, 0, 1, "R5 fetch on fetch-only");
        wr(3, 32'h0C);
        bus(A_ADR, 5, 2'd2, 0, 0, 0, 0, "R5 no kind data");
        bus(A_ADR, 5, 2'd2, 0, 1, 0, 0, "R5 no kind fetch");
        wr(3, 0);

        // R6/R7 channel B data compare, OR mode
        wr(4, B_ADR); wr(5, 4); wr(7, 32'h2C); wr(8, 32'hDEAD_BEEF); wr(9, 32'h0000_FFFF);
        bus(B_ADR, 0, 2'd2, 0, 0, 32'h1234_5678, 1, "R7 B alone breaks, R6 data off");
        wr(10, 32'h80);
        bus(B_ADR, 0, 2'd2, 0, 0, 32'hDEAD_0000, 1, "R6 masked bits differ");
        bus(B_ADR, 0, 2'd2, 0, 0, 32'hDEAC_BEEF, 0, "R6 compared bit differs");
        bus(B_ADR, 0, 2'd2, 0, 0, 32'hDEAD_BEEF, 1, "R6 exact data");

        // R8 sequential mode
        wr(10, 32'h08); wr(3, 32'h2C); wr(1, 4);
        bus(B_ADR, 0, 2'd2, 0, 0, 0, 0, "R8 B unarmed");
        abus(A_ADR, 0, "R8 A arms only");
        bus(B_ADR, 0, 2'd2, 0, 0, 0, 1, "R8 B after A");
        bus(B_ADR, 0, 2'd2, 0, 0, 0, 0, "R8 disarmed by break");
        abus(A_ADR, 0, "R8 A re-arms");
        wr(10, 32'h08);
        bus(B_ADR, 0, 2'd2, 0, 0, 0, 0, "R8 disarmed by ctrl write");

        // R9 after-execution breaks
        wr(10, 32'h400); wr(3, 32'h1C);
        bus(A_ADR, 5, 2'd2, 0, 1, 0, 0, "R9 A fetch held");
        @(negedge clk); @(negedge clk);
        retire(1, "R9 A break after retire");
        retire(0, "R9 retire with nothing held");
        wr(3, 32'h3C);
        bus(A_ADR, 5, 2'd2, 0, 0, 0, 1, "R9 data match not delayed");
        wr(10, 32'h40); wr(7, 32'h1C);
        bus(B_ADR, 0, 2'd2, 0, 1, 0, 0, "R9 B fetch held");
        retire(1, "R9 B break after retire");
        bus(A_ADR, 5, 2'd2, 0, 1, 0, 1, "R9 A fetch before-mode");

        // R10 flags
        wr(10, 0);
        rd(10, 32'h0, "R10 flags cleared by zero");
        abus(A_ADR, 1, "R10 A hit");
        rd(10, 32'h8000, "R10 A flag set");
        wr(10, 32'hC000);
        rd(10, 32'h8000, "R10 write one no effect");
        wr(10, 32'h4000);
        rd(10, 32'h0, "R10 A flag cleared");
        wr(7, 32'h2C);
        bus(B_ADR, 0, 2'd2, 0, 0, 0, 1, "R10 B hit");
        rd(10, 32'h4000, "R10 B flag set");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all expected breaks seen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule